// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a compact 32-bit in-order processor pipeline that runs two real instructions, a register-register add and a word load, through five stages: fetch, decode with register read, ALU, data memory and write-back. Every instruction takes all five stages. An add does nothing in the memory stage, so every register write happens in the last stage and at most one write reaches the register file per clock.

The instruction and data arrays live inside the block and are filled through a simple load port, normally while the core is held in reset. The core has no forwarding network. When decode sees a source register that an older instruction still in flight has not yet written, decode holds and a bubble enters the ALU stage. The register file is write-first, so a value written back is already visible to a decode read in the same cycle. For checking, the program counter and a write-back trace (valid, destination, data) are brought out.

Top module: `pipe5_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and wb_valid_o is 0. After reset, every general register reads as zero until it is written.
- R2: An instruction with bits[31:26]=0, bits[10:6]=0 and bits[5:0]=32 is an add. It writes the sum of the registers selected by bits[25:21] and bits[20:16] into the register selected by bits[15:11].
- R3: An instruction with bits[31:26]=35 is a load. It adds the register selected by bits[25:21] to bits[15:0] sign-extended to 32 bits. It writes the data word at index address[DMEM_AW+1:2] into the register selected by bits[20:16]. Data words are filled through the load port (dmem_ld_i, with ld_addr_i as the word index).
- R4: With no register dependences, the instruction fetched at pc 4*i reports its write-back on wb_* i+4 cycles after reset release. A new instruction is fetched every cycle and pc_o advances by 4 per cycle.
- R5: Write-backs appear on the trace in program order, at most one per cycle, and only for adds and loads with a non-zero destination.
- R6: Register 0 reads as zero, and a write aimed at it produces no trace entry and changes nothing.
- R7: A value in write-back is seen by an instruction in decode in that same cycle, so a consumer three instructions behind its producer does not stall.
- R8: A source register that is the pending destination of the instruction in the ALU or memory stage stalls decode. pc_o holds and a bubble enters the ALU stage. A dependence on the immediately preceding instruction costs 2 cycles; one instruction further back costs 1.
- R9: Every other encoding, including the all-zero word, an add pattern with non-zero bits[10:6] or another funct value, and other opcodes, writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of pipeline state and registers |
| imem_ld_i | input | 1 | Write ld_data_i into instruction word ld_addr_i |
| dmem_ld_i | input | 1 | Write ld_data_i into data word ld_addr_i |
| ld_addr_i | input | max(IMEM_AW,DMEM_AW) | Word index for the load port |
| ld_data_i | input | 32 | Word for the load port |
| pc_o | output | IMEM_AW+2 | Current fetch address |
| wb_valid_o | output | 1 | A register write happens this cycle |
| wb_rd_o | output | 5 | Destination of the write |
| wb_data_o | output | 32 | Data written |

## Verification
The bench uses the default IMEM_AW=6 and DMEM_AW=6. The 64-word data array lets a load with base 0x1000 and offset -4 wrap to the top word, which exposes sign-extension and index-slicing errors. The 8-bit program counter keeps the final pc check within range while trailing zero words run as no-ops. The programs contain back-to-back and one-apart dependences, a consumer three behind a load, and writes to register 0. Together these exercise every stall depth and the write-first path.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_LOADW = 6'd35;
  localparam logic [5:0] FN_ADD   = 6'd32;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [4:0]      ridx_t;

  typedef struct packed {
    logic  wr;
    ridx_t dest;
    logic  is_ld;
    logic  use_rs;
    logic  use_rt;
    ridx_t rs;
    ridx_t rt;
    word_t imm;
  } dec_t;

  typedef struct packed {
    logic  wr;
    ridx_t dest;
    logic  is_ld;
    logic  use_rs;
    logic  use_rt;
    ridx_t rs;
    ridx_t rt;
    word_t opa;
    word_t opb;
    word_t imm;
  } id_ex_t;

  typedef struct packed {
    logic  wr;
    ridx_t dest;
    logic  is_ld;
    word_t res;
  } ex_mem_t;

  typedef struct packed {
    logic  wr;
    ridx_t dest;
    word_t data;
  } mem_wb_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  word_t instr_i,
  output dec_t  dec_o
);
  logic [5:0] op, funct;
  logic [4:0] shamt;
  ridx_t      rd;
  logic       is_add, is_ld;

  assign op     = instr_i[31:26];
  assign rd     = instr_i[15:11];
  assign shamt  = instr_i[10:6];
  assign funct  = instr_i[5:0];
  assign is_add = (op == OP_RTYPE) && (funct == FN_ADD) && (shamt == '0);
  assign is_ld  = (op == OP_LOADW);

  always_comb begin
    dec_o        = '0;
    dec_o.rs     = instr_i[25:21];
    dec_o.rt     = instr_i[20:16];
    dec_o.is_ld  = is_ld;
    dec_o.use_rs = is_add | is_ld;
    dec_o.use_rt = is_add;
    dec_o.dest   = is_add ? rd : instr_i[20:16];
    dec_o.wr     = (is_add | is_ld) && (dec_o.dest != '0);
    dec_o.imm    = {{16{instr_i[15]}}, instr_i[15:0]};
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
#(
  parameter int NRD = 2
)(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ridx_t ra_i [NRD],
  output word_t rd_o [NRD],
  input  logic  we_i,
  input  ridx_t wa_i,
  input  word_t wd_i
);
  word_t regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // write-first read ports
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_o[p] = (ra_i[p] == '0) ? '0 :
                     (we_i && wa_i == ra_i[p]) ? wd_i : regs_q[ra_i[p]];
  end

  assert_wr_visible_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard
  import pipe5_pkg::*;
#(
  parameter int N_OLD = 2
)(
  input  logic                  use_rs_i,
  input  ridx_t                 rs_i,
  input  logic                  use_rt_i,
  input  ridx_t                 rt_i,
  input  logic [N_OLD-1:0]      old_wr_i,
  input  logic [N_OLD-1:0][4:0] old_dest_i,
  output logic                  stall_o
);
  logic [N_OLD-1:0] hit;

  for (genvar g = 0; g < N_OLD; g++) begin : g_cmp
    assign hit[g] = old_wr_i[g] &&
                    ((use_rs_i && rs_i != '0 && rs_i == old_dest_i[g]) ||
                     (use_rt_i && rt_i != '0 && rt_i == old_dest_i[g]));
  end

  assign stall_o = |hit;
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter  int IMEM_AW = 6,
  parameter  int DMEM_AW = 6,
  localparam int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
  localparam int PC_W    = IMEM_AW + 2
)(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             imem_ld_i,
  input  logic             dmem_ld_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [31:0]      ld_data_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             wb_valid_o,
  output logic [4:0]       wb_rd_o,
  output logic [31:0]      wb_data_o
);
  word_t imem_q [2**IMEM_AW];
  word_t dmem_q [2**DMEM_AW];

  always_ff @(posedge clk_i) begin
    if (imem_ld_i) imem_q[ld_addr_i[IMEM_AW-1:0]] <= ld_data_i;
    if (dmem_ld_i) dmem_q[ld_addr_i[DMEM_AW-1:0]] <= ld_data_i;
  end

  logic [PC_W-1:0] pc_q;
  word_t           if_instr_q;
  id_ex_t          id_ex_q;
  ex_mem_t         ex_mem_q;
  mem_wb_t         mem_wb_q;
  logic            stall;

  // fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      if_instr_q <= '0;
    end else if (!stall) begin
      pc_q       <= pc_q + PC_W'(4);
      if_instr_q <= imem_q[pc_q[PC_W-1:2]];
    end
  end

  // decode / register read
  dec_t  dec;
  ridx_t rf_ra [2];
  word_t rf_rd [2];

  pipe5_decode u_dec (.instr_i(if_instr_q), .dec_o(dec));

  assign rf_ra[0] = dec.rs;
  assign rf_ra[1] = dec.rt;

  pipe5_regfile #(.NRD(2)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (rf_ra),
    .rd_o  (rf_rd),
    .we_i  (mem_wb_q.wr),
    .wa_i  (mem_wb_q.dest),
    .wd_i  (mem_wb_q.data)
  );

  pipe5_hazard #(.N_OLD(2)) u_hz (
    .use_rs_i  (dec.use_rs),
    .rs_i      (dec.rs),
    .use_rt_i  (dec.use_rt),
    .rt_i      (dec.rt),
    .old_wr_i  ({ex_mem_q.wr, id_ex_q.wr}),
    .old_dest_i({ex_mem_q.dest, id_ex_q.dest}),
    .stall_o   (stall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_ex_q <= '0;
    end else if (stall) begin
      id_ex_q <= '0;  // bubble
    end else begin
      id_ex_q.wr     <= dec.wr;
      id_ex_q.dest   <= dec.dest;
      id_ex_q.is_ld  <= dec.is_ld;
      id_ex_q.use_rs <= dec.use_rs;
      id_ex_q.use_rt <= dec.use_rt;
      id_ex_q.rs     <= dec.rs;
      id_ex_q.rt     <= dec.rt;
      id_ex_q.opa    <= rf_rd[0];
      id_ex_q.opb    <= rf_rd[1];
      id_ex_q.imm    <= dec.imm;
    end
  end

  // ALU: add serves both instructions
  word_t alu_res;
  assign alu_res = id_ex_q.opa + (id_ex_q.is_ld ? id_ex_q.imm : id_ex_q.opb);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_mem_q <= '0;
    end else begin
      ex_mem_q.wr    <= id_ex_q.wr;
      ex_mem_q.dest  <= id_ex_q.dest;
      ex_mem_q.is_ld <= id_ex_q.is_ld;
      ex_mem_q.res   <= alu_res;
    end
  end

  // memory: adds pass through untouched
  word_t mem_res;
  assign mem_res = ex_mem_q.is_ld ? dmem_q[ex_mem_q.res[DMEM_AW+1:2]] : ex_mem_q.res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_wb_q <= '0;
    end else begin
      mem_wb_q.wr   <= ex_mem_q.wr;
      mem_wb_q.dest <= ex_mem_q.dest;
      mem_wb_q.data <= mem_res;
    end
  end

  assign pc_o       = pc_q;
  assign wb_valid_o = mem_wb_q.wr;
  assign wb_rd_o    = mem_wb_q.dest;
  assign wb_data_o  = mem_wb_q.data;

  assert_pc_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> $stable(pc_q));

  assert_bubble_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> !id_ex_q.wr && !id_ex_q.is_ld);

  assert_no_stale_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((id_ex_q.use_rs && id_ex_q.rs != '0 &&
       ((ex_mem_q.wr && ex_mem_q.dest == id_ex_q.rs) ||
        (mem_wb_q.wr && mem_wb_q.dest == id_ex_q.rs))) ||
      (id_ex_q.use_rt && id_ex_q.rt != '0 &&
       ((ex_mem_q.wr && ex_mem_q.dest == id_ex_q.rt) ||
        (mem_wb_q.wr && mem_wb_q.dest == id_ex_q.rt)))));

  assert_pc_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall |=> pc_q == $past(pc_q) + PC_W'(4));

  assert_no_r0_trace_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_rd_o != '0);
endmodule

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_ld = 1'b0, dmem_ld = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [7:0]  pc;
  logic        wb_valid;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;

  always #2.5 clk = ~clk;

  pipe5_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .imem_ld_i(imem_ld), .dmem_ld_i(dmem_ld),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .pc_o(pc),
    .wb_valid_o(wb_valid), .wb_rd_o(wb_rd), .wb_data_o(wb_data)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  logic [31:0] prog[$];
  string       ptag[$];
  logic [31:0] dm[64];

  logic [4:0]  exp_rd[$];
  logic [31:0] exp_data[$];
  int          exp_cyc[$];
  string       exp_tag[$];
  string       exp_ctag[$];

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_add(input int rd, input int rs, input int rt);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'd32};
  endfunction
  function automatic logic [31:0] enc_lw(input int rt, input int rs, input int imm);
    return {6'd35, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // monitor: pop expected write-backs in order
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      if (exp_rd.size() == 0) begin
        check(1'b0, "R5", "unexpected write-back", {27'd0, wb_rd}, 32'd0);
      end else begin
        automatic logic [4:0]  r = exp_rd.pop_front();
        automatic logic [31:0] d = exp_data.pop_front();
        automatic int          c = exp_cyc.pop_front();
        automatic string       t = exp_tag.pop_front();
        automatic string       ct = exp_ctag.pop_front();
        check(wb_rd == r, t, "write-back destination", {27'd0, wb_rd}, {27'd0, r});
        check(wb_data == d, t, $sformatf("write-back data r%0d", r), wb_data, d);
        check(cyc == c, ct, $sformatf("write-back cycle r%0d", r), cyc, c);
      end
    end
  end

  task automatic run_prog();
    logic [31:0] rf[32];
    int ready[32];
    int d, n, k, stalls;
    for (int i = 0; i < 32; i++) begin rf[i] = '0; ready[i] = 0; end
    d = 0;
    n = prog.size();
    // reference model, written from the requirements
    for (int i = 0; i < n; i++) begin
      logic [31:0] w, val, addr;
      logic        is_add, is_ld;
      int          rs, rt, rd, dest, need;
      w = prog[i];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      is_add = (w[31:26] == 6'd0) && (w[10:6] == 5'd0) && (w[5:0] == 6'd32);
      is_ld  = (w[31:26] == 6'd35);
      need = d + 1;
      if ((is_add || is_ld) && rs != 0 && ready[rs] > need) need = ready[rs];
      if (is_add && rt != 0 && ready[rt] > need) need = ready[rt];
      dest = 0; val = '0;
      if (is_add) begin dest = rd; val = rf[rs] + rf[rt]; end
      if (is_ld) begin
        dest = rt;
        addr = rf[rs] + {{16{w[15]}}, w[15:0]};
        val  = dm[addr[7:2]];
      end
      if ((is_add || is_ld) && dest != 0) begin
        rf[dest] = val;
        ready[dest] = need + 3;
        exp_rd.push_back(5'(dest));
        exp_data.push_back(val);
        exp_cyc.push_back(need + 3);
        exp_tag.push_back(ptag[i]);
        exp_ctag.push_back((need > d + 1) ? "R8" : "R4");
      end
      d = need;
    end
    stalls = d - n;
    k = d + 8;

    // load memories while held in reset
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_ld = 1'b1; dmem_ld = 1'b1; ld_addr = 6'(i);
      ld_data = (i < n) ? prog[i] : 32'd0;
      @(negedge clk);
      imem_ld = 1'b0; ld_data = dm[i];
    end
    @(negedge clk);
    dmem_ld = 1'b0;
    check(pc == 8'd0, "R1", "pc in reset", {24'd0, pc}, 32'd0);
    check(!wb_valid, "R1", "trace valid in reset", {31'd0, wb_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (k) @(negedge clk);
    check(pc == 8'(4 * (k - stalls)), "R8", "pc after run", {24'd0, pc}, 32'(8'(4 * (k - stalls))));
    check(exp_rd.size() == 0, "R5", "write-backs missing", exp_rd.size(), 32'd0);
    exp_rd.delete(); exp_data.delete(); exp_cyc.delete(); exp_tag.delete(); exp_ctag.delete();
    rst_n = 1'b0;
  endtask

  task automatic put(input logic [31:0] w, input string t);
    prog.push_back(w);
    ptag.push_back(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);

    // program 1: adds, loads, sign extension, ignored encodings
    prog.delete(); ptag.delete();
    for (int i = 0; i < 64; i++) dm[i] = 32'h1000_0000 + 32'(i);
    dm[0] = 32'd5; dm[1] = 32'd7; dm[2] = 32'hFFFF_FFFD; dm[3] = 32'h0000_1000;
    dm[63] = 32'hCAFE_0001;
    put(enc_add(7, 1, 2), "R1");
    put(enc_lw(1, 0, 0), "R3");
    put(enc_lw(2, 0, 4), "R3");
    put(enc_lw(3, 0, 8), "R3");
    put(enc_lw(4, 0, 12), "R3");
    put(32'd0, "R9");
    put({6'd0, 5'd1, 5'd2, 5'd8, 5'd1, 6'd32}, "R9");
    put({6'd43, 5'd0, 5'd9, 16'd0}, "R9");
    put({6'd0, 5'd1, 5'd2, 5'd10, 5'd0, 6'd33}, "R9");
    put(enc_add(11, 8, 1), "R9");
    put(enc_add(12, 9, 10), "R9");
    put(enc_add(5, 1, 2), "R2");
    put(enc_add(6, 3, 4), "R2");
    put(enc_lw(13, 4, -4), "R3");
    put(enc_lw(14, 0, 20), "R3");
    run_prog();

    // program 2: dependences, register 0, write-first
    prog.delete(); ptag.delete();
    for (int i = 0; i < 64; i++) dm[i] = '0;
    dm[0] = 32'd8; dm[1] = 32'd3; dm[2] = 32'd100; dm[27] = 32'h55;
    put(enc_lw(1, 0, 0), "R3");
    put(enc_lw(2, 0, 4), "R3");
    put(enc_add(3, 1, 2), "R8");
    put(enc_add(4, 3, 3), "R8");
    put(enc_add(5, 1, 1), "R2");
    put(enc_add(6, 4, 5), "R8");
    put(enc_add(0, 1, 2), "R6");
    put(enc_add(7, 0, 2), "R6");
    put(enc_lw(8, 1, 0), "R3");
    put(enc_add(9, 1, 1), "R2");
    put(enc_add(10, 1, 1), "R2");
    put(enc_add(11, 8, 1), "R7");
    put(enc_lw(12, 11, 0), "R8");
    put(enc_add(13, 12, 12), "R8");
    run_prog();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule